// File: doc/BRIEF.md
# Set-Associative Page Translation Buffer with Test Registers

This block caches translations from a 20-bit linear page number to a 20-bit physical page number. It holds 32 entries as eight sets of four ways. The low three bits of the linear page pick the set, and the full page is compared against all four ways at once. The normal lookup port is combinational: a page goes in, and a hit flag, the physical page and three attribute bits come out in the same cycle. When the caller asserts the request strobe, a hit also refreshes that set's replacement state.

Software does not fill or inspect entries through the lookup port. It uses two 32-bit registers instead. The control register holds a linear page, a valid bit, the attribute bits and a command bit. A write to the control register starts a test operation in the same clock edge. A test write stores the page, valid and attribute bits, together with the physical page held in the data register. The way comes either from the data register's way field or from the tree pseudo-LRU victim. A test lookup loads the data register with the matching entry's physical page, the hitting way, a hit flag and the set's replacement bits.

Top module: `tlb_testport`

## Requirements
- R1: After reset every entry is invalid, every set's replacement bits are 000, and both registers read zero. A lookup misses with physical page and attributes zero.
- R2: A lookup hits only when a valid way of set `lk_vpage[2:0]` stores exactly `lk_vpage`. On a hit it returns that way's physical page and attributes. On a miss both outputs are zero.
- R3: A write to the control register stores the linear page in bits 31:12, valid in bit 11, attributes in bits 10:8 and the command in bit 0. All other bits read zero.
- R4: A write to the data register stores the physical page in bits 31:12, the replacement bits in 9:7, the way-select flag in bit 4 and the way number in bits 3:2. All other bits read zero.
- R5: A control write with command 1 stores the control register's page, valid and attributes, plus the data register's physical page, into the chosen way of the page's set. The entry is visible to lookups from the next cycle. Writing valid 0 removes the entry.
- R6: For a test write, a way-select flag of 1 uses the way number from bits 3:2. A flag of 0 uses the pseudo-LRU victim.
- R7: The replacement bits of a set are b0 (bit 7), b1 (bit 8) and b2 (bit 9). b0=0 points at ways {0,1} and b0=1 at {2,3}. b1 picks way 0 or 1, and b2 picks way 2 or 3. Using a way points the bits away from it. From reset, victim-mode fills of one set land in ways 0, 2, 1, 3.
- R8: A control write with command 0 is a test lookup. On a hit the data register receives the physical page, flag 1, the hitting way and the set's replacement bits. On a miss it receives a zero page, flag 0, way 0 and the replacement bits. A test lookup takes priority over a data-register write in the same cycle and leaves the replacement bits unchanged.
- R9: A lookup hit with the request strobe high updates the set's replacement bits. With the strobe low the bits are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request; a hit refreshes replacement state |
| lk_vpage | input | 20 | Linear page to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_attr | output | 3 | Attribute bits of the hitting entry |
| lk_ppage | output | 20 | Physical page of the hitting entry |
| ctl_wr | input | 1 | Control register write; starts a test operation |
| ctl_wdata | input | 32 | Control register write value |
| ctl_rdata | output | 32 | Control register contents |
| dat_wr | input | 1 | Data register write |
| dat_wdata | input | 32 | Data register write value |
| dat_rdata | output | 32 | Data register contents |

## Verification
One set is filled in victim mode from reset. Each page is then read back through test lookups, which shows the 0, 2, 1, 3 placement order and the reported way numbers. Lookups with and without the request strobe, each followed by a test lookup of the replacement bits, show whether an update was made. A forced-way fill, an invalidating write and a fill into a second set check way selection, removal and set independence. Reserved register bits are written as ones, and lookups use pages that share a set index with a stored page, to catch a truncated tag compare.

// File: rtl/tlb_tp_pkg.sv
package tlb_tp_pkg;

   localparam int PAGE_W = 20;
   localparam int ATTR_W = 3;
   localparam int PLRU_W = 3;

   localparam logic [31:0] CTL_KEEP = 32'hFFFF_FF01;

   typedef struct packed {
      logic [PAGE_W-1:0] ppage;
      logic [PLRU_W-1:0] plru;
      logic              force_way;
      logic [1:0]        way_sel;
   } dat_reg_t;

   function automatic logic [1:0] plru_victim(input logic [PLRU_W-1:0] b);
      return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
   endfunction

   function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] b,
                                                    input logic [1:0] w);
      logic [PLRU_W-1:0] n;
      n    = b;
      n[0] = ~w[1];
      if (w[1]) n[2] = ~w[0];
      else      n[1] = ~w[0];
      return n;
   endfunction

endpackage

// File: rtl/tlb_tp_match.sv
module tlb_tp_match #(
   parameter int WAYS   = 4,
   parameter int PAGE_W = 20,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [PAGE_W-1:0]            page,
   input  logic [WAYS-1:0][PAGE_W-1:0]  tags,
   input  logic [WAYS-1:0]              valid,
   output logic                         hit,
   output logic [WAY_W-1:0]             way
);

   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = valid[w] && (tags[w] == page);
   end

   always_comb begin
      hit = |eq;
      way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (eq[w]) way = WAY_W'(w);
      end
   end

endmodule

// File: rtl/tlb_tp_plru.sv
module tlb_tp_plru
   import tlb_tp_pkg::*;
#(
   parameter int SETS  = 8,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              touch_en,
   input  logic [SET_W-1:0]  touch_set,
   input  logic [1:0]        touch_way,
   input  logic [SET_W-1:0]  rd_set,
   output logic [PLRU_W-1:0] rd_bits,
   output logic [1:0]        rd_victim
);

   logic [PLRU_W-1:0] st_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) st_q[s] <= '0;
      end else if (touch_en) begin
         st_q[touch_set] <= plru_touch(st_q[touch_set], touch_way);
      end
   end

   assign rd_bits   = st_q[rd_set];
   assign rd_victim = plru_victim(rd_bits);

endmodule

// File: rtl/tlb_testport.sv
module tlb_testport
   import tlb_tp_pkg::*;
#(
   parameter int SETS = 8,
   parameter int WAYS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [19:0]       lk_vpage,
   output logic              lk_hit,
   output logic [2:0]        lk_attr,
   output logic [19:0]       lk_ppage,
   input  logic              ctl_wr,
   input  logic [31:0]       ctl_wdata,
   output logic [31:0]       ctl_rdata,
   input  logic              dat_wr,
   input  logic [31:0]       dat_wdata,
   output logic [31:0]       dat_rdata
);

   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);

   if (WAYS != 4) begin : g_bad_ways
      $error("tlb_testport: the register layout needs exactly four ways");
   end
   if (SETS < 2 || (1 << SET_W) != SETS || SET_W > PAGE_W) begin : g_bad_sets
      $error("tlb_testport: SETS must be a power of two between 2 and 2**PAGE_W");
   end

   logic [WAYS-1:0][PAGE_W-1:0] vtag_q [SETS];
   logic [WAYS-1:0][PAGE_W-1:0] ppn_q  [SETS];
   logic [WAYS-1:0][ATTR_W-1:0] attr_q [SETS];
   logic [WAYS-1:0]             val_q  [SETS];

   logic [31:0] ctl_q;
   dat_reg_t    dat_q;

   // normal lookup path
   logic [SET_W-1:0] lk_set;
   logic [WAY_W-1:0] lk_way;
   assign lk_set = lk_vpage[SET_W-1:0];

   tlb_tp_match #(.WAYS(WAYS), .PAGE_W(PAGE_W)) u_lk_match (
      .page  (lk_vpage),
      .tags  (vtag_q[lk_set]),
      .valid (val_q[lk_set]),
      .hit   (lk_hit),
      .way   (lk_way)
   );

   assign lk_ppage = lk_hit ? ppn_q[lk_set][lk_way]  : '0;
   assign lk_attr  = lk_hit ? attr_q[lk_set][lk_way] : '0;

   // test operation path
   logic [PAGE_W-1:0] t_page;
   logic [SET_W-1:0]  t_set;
   logic              t_do_wr, t_do_rd, t_hit;
   logic [WAY_W-1:0]  t_way, fill_way;
   logic [PLRU_W-1:0] t_plru;
   logic [1:0]        t_victim;

   assign t_page  = ctl_wdata[31:12];
   assign t_set   = t_page[SET_W-1:0];
   assign t_do_wr = ctl_wr &&  ctl_wdata[0];
   assign t_do_rd = ctl_wr && !ctl_wdata[0];

   tlb_tp_match #(.WAYS(WAYS), .PAGE_W(PAGE_W)) u_tp_match (
      .page  (t_page),
      .tags  (vtag_q[t_set]),
      .valid (val_q[t_set]),
      .hit   (t_hit),
      .way   (t_way)
   );

   assign fill_way = dat_q.force_way ? WAY_W'(dat_q.way_sel) : WAY_W'(t_victim);

   // replacement state: a test write outranks a lookup hit in the same cycle
   logic             touch_en;
   logic [SET_W-1:0] touch_set;
   logic [1:0]       touch_way;

   assign touch_en  = t_do_wr || (lk_req && lk_hit);
   assign touch_set = t_do_wr ? t_set : lk_set;
   assign touch_way = t_do_wr ? 2'(fill_way) : 2'(lk_way);

   tlb_tp_plru #(.SETS(SETS)) u_plru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_set (touch_set),
      .touch_way (touch_way),
      .rd_set    (t_set),
      .rd_bits   (t_plru),
      .rd_victim (t_victim)
   );

   // entry storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) val_q[s] <= '0;
      end else if (t_do_wr) begin
         val_q[t_set][fill_way] <= ctl_wdata[11];
      end
   end

   always_ff @(posedge clk) begin
      if (t_do_wr) begin
         vtag_q[t_set][fill_way] <= t_page;
         attr_q[t_set][fill_way] <= ctl_wdata[10:8];
         ppn_q[t_set][fill_way]  <= dat_q.ppage;
      end
   end

   // registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         dat_q <= '0;
      end else begin
         if (ctl_wr) ctl_q <= ctl_wdata & CTL_KEEP;
         if (t_do_rd) begin
            dat_q.ppage     <= t_hit ? ppn_q[t_set][t_way] : '0;
            dat_q.plru      <= t_plru;
            dat_q.force_way <= t_hit;
            dat_q.way_sel   <= t_hit ? 2'(t_way) : 2'b00;
         end else if (dat_wr) begin
            dat_q.ppage     <= dat_wdata[31:12];
            dat_q.plru      <= dat_wdata[9:7];
            dat_q.force_way <= dat_wdata[4];
            dat_q.way_sel   <= dat_wdata[3:2];
         end
      end
   end

   assign ctl_rdata = ctl_q;
   assign dat_rdata = {dat_q.ppage, 2'b00, dat_q.plru, 2'b00,
                       dat_q.force_way, dat_q.way_sel, 2'b00};

endmodule

// File: rtl/tlb_testport_chk.sv
module tlb_testport_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        lk_req,
   input logic [19:0] lk_vpage,
   input logic        lk_hit,
   input logic [2:0]  lk_attr,
   input logic [19:0] lk_ppage,
   input logic        ctl_wr,
   input logic [31:0] ctl_wdata,
   input logic [31:0] ctl_rdata,
   input logic        dat_wr,
   input logic [31:0] dat_wdata,
   input logic [31:0] dat_rdata
);

   p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_ppage == 20'h0 && lk_attr == 3'h0));

   p_ctl_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> ctl_rdata == ($past(ctl_wdata) & 32'hFFFF_FF01));

   p_fill_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[0] && ctl_wdata[11])
      |=> (lk_vpage != $past(ctl_wdata[31:12]) || lk_hit));

   p_miss_report_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[0])
      |=> (dat_rdata[4] || (dat_rdata[31:12] == 20'h0 && dat_rdata[3:2] == 2'b00)));

   p_fill_then_find_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[0] && $past(ctl_wr && ctl_wdata[0] && ctl_wdata[11])
       && ctl_wdata[31:12] == $past(ctl_wdata[31:12]))
      |=> dat_rdata[4]);

endmodule

bind tlb_testport tlb_testport_chk u_chk (.*);

// File: tb/tlb_testport_bench.sv
module tlb_testport_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [19:0] lk_vpage = '0;
   logic        lk_hit;
   logic [2:0]  lk_attr;
   logic [19:0] lk_ppage;
   logic        ctl_wr = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic [31:0] ctl_rdata;
   logic        dat_wr = 1'b0;
   logic [31:0] dat_wdata = '0;
   logic [31:0] dat_rdata;

   always #5 clk = ~clk;

   tlb_testport u_tlb_testport (.*);

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // monitor: compare every queued expectation one step after the edge
   always begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = q.pop_front();
         case (it.sel)
            0:       act = {8'h0, lk_hit, lk_attr, lk_ppage};
            1:       act = dat_rdata;
            default: act = ctl_rdata;
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_val(int sel, logic [31:0] e, string t);
      item_t it;
      it.sel = sel;
      it.exp = e;
      it.tag = t;
      q.push_back(it);
   endtask

   task automatic idle_all();
      lk_req = 1'b0;
      ctl_wr = 1'b0;
      dat_wr = 1'b0;
   endtask

   task automatic do_dat(logic [31:0] v);
      @(negedge clk);
      idle_all();
      dat_wr = 1'b1;
      dat_wdata = v;
   endtask

   task automatic do_ctl(logic [31:0] v);
      @(negedge clk);
      idle_all();
      ctl_wr = 1'b1;
      ctl_wdata = v;
   endtask

   task automatic do_look(logic [19:0] p, logic req);
      @(negedge clk);
      idle_all();
      lk_vpage = p;
      lk_req = req;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      do_look(20'h00010, 1'b0);
      expect_val(0, 32'h0, "R1 lookup after reset");
      expect_val(1, 32'h0, "R1 data reg");
      expect_val(2, 32'h0, "R1 control reg");

      // R4 data register layout with reserved bits set
      do_dat(32'hABCD_EC63);
      expect_val(1, 32'hABCD_E000, "R4 data layout");

      // R3 control layout, also a victim-mode fill of page 0x00010 (way 0)
      do_ctl(32'h0001_0D0F);
      expect_val(2, 32'h0001_0D01, "R3 control layout");

      do_look(20'h00010, 1'b0);
      expect_val(0, 32'h00DA_BCDE, "R2 R5 hit after fill");
      do_look(20'h00018, 1'b0);
      expect_val(0, 32'h0, "R2 same set other page misses");

      // fill three more pages of set 0 in victim mode
      do_dat(32'h1111_1000); do_ctl(32'h0002_0801);
      do_dat(32'h2222_2000); do_ctl(32'h0002_8801);
      do_dat(32'h3333_3000); do_ctl(32'h0003_0801);

      // R7 placement order 0,2,1,3; R8 test lookup reports
      do_ctl(32'h0002_8800);
      expect_val(1, 32'h2222_2014, "R7 R8 page C in way 1");
      do_ctl(32'h0002_0800);
      expect_val(1, 32'h1111_1018, "R7 R8 page B in way 2");
      do_ctl(32'h0003_0800);
      expect_val(1, 32'h3333_301C, "R7 R8 page D in way 3");
      do_ctl(32'h0001_0800);
      expect_val(1, 32'hABCD_E010, "R7 R8 page A in way 0");
      do_ctl(32'h0003_8800);
      expect_val(1, 32'h0, "R8 test lookup miss");

      // R9 lookup with strobe touches way 2
      do_look(20'h00020, 1'b1);
      expect_val(0, 32'h0081_1111, "R9 strobed hit");
      do_ctl(32'h0001_0800);
      expect_val(1, 32'hABCD_E210, "R9 bits after strobed hit");
      do_look(20'h00010, 1'b0);
      expect_val(0, 32'h00DA_BCDE, "R9 unstrobed hit");
      do_ctl(32'h0001_0800);
      expect_val(1, 32'hABCD_E210, "R9 bits unchanged without strobe");

      // R6 victim mode evicts way 0
      do_dat(32'h4444_4000); do_ctl(32'h0004_0801);
      do_look(20'h00010, 1'b0);
      expect_val(0, 32'h0, "R6 victim replaced page A");
      do_look(20'h00040, 1'b0);
      expect_val(0, 32'h0084_4444, "R6 new page E");

      // R6 forced way 3
      do_dat(32'h5555_501C); do_ctl(32'h0004_8801);
      do_look(20'h00030, 1'b0);
      expect_val(0, 32'h0, "R6 forced way replaced page D");
      do_look(20'h00048, 1'b0);
      expect_val(0, 32'h0085_5555, "R6 forced page F");
      do_look(20'h00020, 1'b0);
      expect_val(0, 32'h0081_1111, "R6 way 2 kept");
      do_ctl(32'h0004_8800);
      expect_val(1, 32'h5555_511C, "R6 R8 forced page read back");

      // R5 invalidate with valid 0 (data reg holds forced way 3)
      do_ctl(32'h0004_8001);
      do_look(20'h00048, 1'b0);
      expect_val(0, 32'h0, "R5 invalidated entry misses");

      // R7 second set has its own state
      do_dat(32'h7777_7000); do_ctl(32'h0001_1801);
      do_ctl(32'h0001_1800);
      expect_val(1, 32'h7777_7190, "R7 set 1 first fill");
      do_ctl(32'h0002_0800);
      expect_val(1, 32'h1111_1118, "R7 set 0 bits untouched");

      // R8 test lookup outranks same-cycle data write
      @(negedge clk);
      idle_all();
      ctl_wr = 1'b1;
      ctl_wdata = 32'h0004_0800;
      dat_wr = 1'b1;
      dat_wdata = 32'hFFFF_F000;
      expect_val(1, 32'h4444_4110, "R8 lookup wins over data write");

      @(negedge clk);
      idle_all();
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule